// File: doc/BRIEF.md
# Programmable Panel Sync Pulse Generator

This block times a flat-panel display from its pixel clock. A pixel counter runs across each line and a line counter runs down each frame. From these two counts the block drives a horizontal sync pulse, a vertical sync pulse and a one-cycle frame-start strobe. Line length, frame height and horizontal pulse width are static configuration inputs. The placement of the horizontal pulse, the length of the vertical pulse in lines and the vertical pulse polarity are software settings held in three byte-wide registers.

Software writes the registers at any time and reads back the programmed values at once. The sync logic only uses a new setting from the next frame onward, so no pulse changes shape part way through a frame. Out-of-range codes are clamped to the largest legal value when they are written.

Top module: `panel_sync_gen`

## Requirements
- R1: After reset all register fields are 0, both counters are 0, and frame_start is high in the first cycle after reset is released.
- R2: Register layout. Address 0x22 holds the low 8 bits of the 10-bit horizontal start code. Address 0x23 bits 1:0 hold start bits 9:8 and bits 7:2 read 0. Address 0x24 bits 2:0 hold the vertical width code, bit 7 holds the polarity and bits 6:3 read 0. Any other address reads 0, and writes to other addresses change nothing.
- R3: A write that would make the start code 0x3FF stores 0x3FE. A vertical width code of 7 is stored as 6.
- R4: The pixel count runs from 0 to cfg_htotal-1 and the line count runs from 0 to cfg_vtotal-1. frame_start is high exactly in the cycle where both counts are 0.
- R5: hsync is active high. It is high at pixel positions p with start+1 <= p < start+1+cfg_hs_width. The pulse is cut off at the end of the line.
- R6: The vertical pulse is active on lines 0 through width, which is width+1 whole lines. It starts on the first pixel of line 0.
- R7: With polarity 1, vsync is high while the vertical pulse is active. With polarity 0, vsync is low while the pulse is active and high otherwise.
- R8: Register readback shows a write in the next cycle. hsync and vsync keep using the previous settings until the counters wrap to the start of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| cfg_htotal | input | HCNT_W | Pixel clocks per line |
| cfg_vtotal | input | VCNT_W | Lines per frame |
| cfg_hs_width | input | HCNT_W | Horizontal pulse width in pixel clocks |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, polarity selectable |
| frame_start | output | 1 | One-cycle strobe at pixel 0 of line 0 |

## Verification
The properties take for granted that cfg_htotal and cfg_vtotal are at least 2, that cfg_hs_width is at least 1, and that all three stay constant while out of reset. Without these conditions the counter range checks and the single-cycle strobe check have no meaning. The stimulus sets these inputs once before reset is released and never changes them. It uses a short 20-pixel by 12-line frame, so that many frames can run, including one where the horizontal pulse is cut off at the end of the line.

// File: rtl/psg_pkg.sv
package psg_pkg;

    localparam int HS_START_W = 10;
    localparam int VS_WIDTH_W = 3;
    localparam int REG_W      = 8;

    localparam logic [REG_W-1:0] ADDR_HS_LO = 8'h22;
    localparam logic [REG_W-1:0] ADDR_HS_HI = 8'h23;
    localparam logic [REG_W-1:0] ADDR_VS    = 8'h24;

    localparam logic [HS_START_W-1:0] HS_START_MAX = 10'h3FE;
    localparam logic [VS_WIDTH_W-1:0] VS_WIDTH_MAX = 3'd6;

    localparam int HS_HI_W = HS_START_W - REG_W;
    localparam int VS_POL_BIT = REG_W - 1;

    typedef struct packed {
        logic [HS_START_W-1:0] hs_start;
        logic [VS_WIDTH_W-1:0] vs_width;
        logic                  vs_pol;
    } sync_cfg_t;

    function automatic logic [HS_START_W-1:0] clamp_hs(input logic [HS_START_W-1:0] v);
        return (v > HS_START_MAX) ? HS_START_MAX : v;
    endfunction

    function automatic logic [VS_WIDTH_W-1:0] clamp_vs(input logic [VS_WIDTH_W-1:0] v);
        return (v > VS_WIDTH_MAX) ? VS_WIDTH_MAX : v;
    endfunction

endpackage

// File: rtl/psg_regs.sv
module psg_regs
    import psg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             frame_load,
    output sync_cfg_t        prog_q,
    output sync_cfg_t        act_q
);

    sync_cfg_t             prog_d;
    logic [HS_START_W-1:0] start_raw;

    always_comb begin
        prog_d    = prog_q;
        start_raw = prog_q.hs_start;
        if (reg_we) begin
            case (reg_addr)
                ADDR_HS_LO: start_raw = {prog_q.hs_start[HS_START_W-1:REG_W], reg_wdata};
                ADDR_HS_HI: start_raw = {reg_wdata[HS_HI_W-1:0], prog_q.hs_start[REG_W-1:0]};
                ADDR_VS: begin
                    prog_d.vs_width = clamp_vs(reg_wdata[VS_WIDTH_W-1:0]);
                    prog_d.vs_pol   = reg_wdata[VS_POL_BIT];
                end
                default: ;
            endcase
        end
        prog_d.hs_start = clamp_hs(start_raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q <= '0;
            act_q  <= '0;
        end else begin
            prog_q <= prog_d;
            if (frame_load) begin
                act_q <= prog_q;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_HS_LO: reg_rdata = prog_q.hs_start[REG_W-1:0];
            ADDR_HS_HI: reg_rdata[HS_HI_W-1:0] = prog_q.hs_start[HS_START_W-1:REG_W];
            ADDR_VS: begin
                reg_rdata[VS_WIDTH_W-1:0] = prog_q.vs_width;
                reg_rdata[VS_POL_BIT]     = prog_q.vs_pol;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/psg_timing.sv
module psg_timing #(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HCNT_W-1:0] cfg_htotal,
    input  logic [VCNT_W-1:0] cfg_vtotal,
    output logic [HCNT_W-1:0] h_cnt,
    output logic [VCNT_W-1:0] v_cnt,
    output logic              frame_last,
    output logic              frame_start
);

    logic line_end;
    logic last_line;

    assign line_end    = h_cnt >= (cfg_htotal - HCNT_W'(1));
    assign last_line   = v_cnt >= (cfg_vtotal - VCNT_W'(1));
    assign frame_last  = line_end && last_line;
    assign frame_start = (h_cnt == '0) && (v_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= last_line ? '0 : v_cnt + VCNT_W'(1);
        end else begin
            h_cnt <= h_cnt + HCNT_W'(1);
        end
    end

endmodule

// File: rtl/psg_pulse.sv
module psg_pulse
    import psg_pkg::*;
#(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 10
) (
    input  logic [HCNT_W-1:0] h_cnt,
    input  logic [VCNT_W-1:0] v_cnt,
    input  logic [HCNT_W-1:0] cfg_hs_width,
    input  sync_cfg_t         act,
    output logic              hsync,
    output logic              vsync
);

    localparam int HC_W = ((HCNT_W > HS_START_W) ? HCNT_W : HS_START_W) + 2;
    localparam int VC_W = ((VCNT_W > VS_WIDTH_W) ? VCNT_W : VS_WIDTH_W) + 1;

    logic [HC_W-1:0] h_ext;
    logic [HC_W-1:0] hs_first;
    logic [HC_W-1:0] hs_stop;
    logic [VC_W-1:0] v_ext;
    logic [VC_W-1:0] vs_last;
    logic            vs_on;

    always_comb begin
        h_ext    = HC_W'(h_cnt);
        hs_first = HC_W'(act.hs_start) + HC_W'(1);
        hs_stop  = hs_first + HC_W'(cfg_hs_width);
        hsync    = (h_ext >= hs_first) && (h_ext < hs_stop);
    end

    always_comb begin
        v_ext   = VC_W'(v_cnt);
        vs_last = VC_W'(act.vs_width);
        vs_on   = v_ext <= vs_last;
        vsync   = act.vs_pol ? vs_on : !vs_on;
    end

endmodule

// File: rtl/panel_sync_gen.sv
module panel_sync_gen
    import psg_pkg::*;
#(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [HCNT_W-1:0] cfg_htotal,
    input  logic [VCNT_W-1:0] cfg_vtotal,
    input  logic [HCNT_W-1:0] cfg_hs_width,
    output logic              hsync,
    output logic              vsync,
    output logic              frame_start
);

    sync_cfg_t         prog_cfg;
    sync_cfg_t         act_cfg;
    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;
    logic              frame_last;
    logic              act_pol;

    assign act_pol = act_cfg.vs_pol;

    psg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .frame_load (frame_last),
        .prog_q     (prog_cfg),
        .act_q      (act_cfg)
    );

    psg_timing #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_timing (
        .clk         (clk),
        .rst         (rst),
        .cfg_htotal  (cfg_htotal),
        .cfg_vtotal  (cfg_vtotal),
        .h_cnt       (h_cnt),
        .v_cnt       (v_cnt),
        .frame_last  (frame_last),
        .frame_start (frame_start)
    );

    psg_pulse #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_pulse (
        .h_cnt        (h_cnt),
        .v_cnt        (v_cnt),
        .cfg_hs_width (cfg_hs_width),
        .act          (act_cfg),
        .hsync        (hsync),
        .vsync        (vsync)
    );

endmodule

// File: rtl/psg_checker.sv
module psg_checker #(
    parameter int HCNT_W = 10,
    parameter int VCNT_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [HCNT_W-1:0] cfg_htotal,
    input logic [VCNT_W-1:0] cfg_vtotal,
    input logic [HCNT_W-1:0] h_cnt,
    input logic [VCNT_W-1:0] v_cnt,
    input logic              frame_last,
    input logic              act_pol,
    input logic              hsync,
    input logic              vsync,
    input logic              frame_start
);

    p_hcnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        h_cnt < cfg_htotal);

    p_vcnt_range_r4: assert property (@(posedge clk) disable iff (rst)
        v_cnt < cfg_vtotal);

    p_fs_single_r4: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    p_pad_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h23) |-> (reg_rdata[7:2] == 6'd0));

    p_pad_vs_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h24) |-> (reg_rdata[6:3] == 4'd0));

    p_vs_clamp_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 8'h24) |-> (reg_rdata[2:0] != 3'd7));

    p_hs_idle_pix0_r5: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == '0) |-> !hsync);

    p_vs_origin_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (vsync == act_pol));

    p_act_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(act_pol));

endmodule

bind panel_sync_gen psg_checker #(.HCNT_W(HCNT_W), .VCNT_W(VCNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_rdata   (reg_rdata),
    .cfg_htotal  (cfg_htotal),
    .cfg_vtotal  (cfg_vtotal),
    .h_cnt       (h_cnt),
    .v_cnt       (v_cnt),
    .frame_last  (frame_last),
    .act_pol     (act_pol),
    .hsync       (hsync),
    .vsync       (vsync),
    .frame_start (frame_start)
);

// File: tb/tb_panel_sync_gen.sv
module tb_panel_sync_gen;

    localparam int HW  = 10;
    localparam int VW  = 10;
    localparam int HT  = 20;
    localparam int VT  = 12;
    localparam int HSW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [HW-1:0] cfg_htotal = HW'(HT);
    logic [VW-1:0] cfg_vtotal = VW'(VT);
    logic [HW-1:0] cfg_hs_width = HW'(HSW);
    logic          hsync, vsync, frame_start;

    always #2 clk = ~clk;

    panel_sync_gen #(.HCNT_W(HW), .VCNT_W(VW)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cfg_htotal(cfg_htotal), .cfg_vtotal(cfg_vtotal),
        .cfg_hs_width(cfg_hs_width),
        .hsync(hsync), .vsync(vsync), .frame_start(frame_start)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit hs;
        bit vs;
        bit fs;
        int h;
        int v;
    } exp_t;

    exp_t sbq[$];

    // Reference model built from the requirements
    int m_h, m_v;
    int p_start, p_vw, a_start, a_vw;
    bit p_pol, a_pol;

    function automatic int lim_start(input int v);
        return (v > 'h3FE) ? 'h3FE : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_h = 0; m_v = 0;
            p_start = 0; p_vw = 0; p_pol = 0;
            a_start = 0; a_vw = 0; a_pol = 0;
        end else begin
            if (m_h == HT-1 && m_v == VT-1) begin
                a_start = p_start; a_vw = p_vw; a_pol = p_pol;
            end
            if (m_h == HT-1) begin
                m_h = 0;
                m_v = (m_v == VT-1) ? 0 : m_v + 1;
            end else begin
                m_h = m_h + 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h22: p_start = lim_start((p_start & 'h300) | int'(reg_wdata));
                    8'h23: p_start = lim_start((int'(reg_wdata & 8'h03) << 8) | (p_start & 'hFF));
                    8'h24: begin
                        p_vw  = (reg_wdata[2:0] == 3'd7) ? 6 : int'(reg_wdata[2:0]);
                        p_pol = reg_wdata[7];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Driver side of the scoreboard: push expected outputs each cycle
    always @(negedge clk) begin
        exp_t e;
        bit von;
        if (!rst) begin
            e.h  = m_h;
            e.v  = m_v;
            e.hs = (m_h >= a_start + 1) && (m_h < a_start + 1 + HSW);
            von  = (m_v <= a_vw);
            e.vs = a_pol ? von : !von;
            e.fs = (m_h == 0) && (m_v == 0);
            sbq.push_back(e);
        end
    end

    // Monitor: pop and compare
    always @(negedge clk) begin
        exp_t e;
        #1;
        while (sbq.size() > 0) begin
            e = sbq.pop_front();
            checks++;
            if (hsync !== e.hs) begin
                errors++;
                $display("FAIL R5 hsync h=%0d v=%0d got %b exp %b", e.h, e.v, hsync, e.hs);
            end
            checks++;
            if (vsync !== e.vs) begin
                errors++;
                $display("FAIL R6 R7 vsync h=%0d v=%0d got %b exp %b", e.h, e.v, vsync, e.vs);
            end
            checks++;
            if (frame_start !== e.fs) begin
                errors++;
                $display("FAIL R4 frame_start h=%0d v=%0d got %b exp %b", e.h, e.v, frame_start, e.fs);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp_v, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        checks++;
        if (reg_rdata !== exp_v) begin
            errors++;
            $display("FAIL %s read 0x%02h got 0x%02h exp 0x%02h", tag, a, reg_rdata, exp_v);
        end
    endtask

    task automatic run_frames(input int n);
        repeat (n * HT * VT) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired got running exp finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (frame_start !== 1'b1 || hsync !== 1'b0 || vsync !== 1'b0) begin
            errors++;
            $display("FAIL R1 outputs after reset got fs=%b hs=%b vs=%b exp fs=1 hs=0 vs=0",
                     frame_start, hsync, vsync);
        end
        rd(8'h22, 8'h00, "R1");
        rd(8'h23, 8'h00, "R1");
        rd(8'h24, 8'h00, "R1");
        run_frames(2);

        // R8: readback immediate, outputs deferred to next frame
        wr(8'h22, 8'h05);
        rd(8'h22, 8'h05, "R8");
        wr(8'h24, 8'h82);
        rd(8'h24, 8'h82, "R2");
        run_frames(2);

        // R5 truncation at line end: start 17 -> pixels 18 and 19 only
        wr(8'h22, 8'h11);
        run_frames(2);

        // R3 clamp of start code
        wr(8'h23, 8'h03);
        rd(8'h23, 8'h03, "R2");
        wr(8'h22, 8'hFF);
        rd(8'h22, 8'hFE, "R3");
        wr(8'h23, 8'hFF);
        rd(8'h23, 8'h03, "R2");
        rd(8'h22, 8'hFE, "R3");
        run_frames(1);

        // R3 clamp of width code, R6 longest pulse, R7 high polarity
        wr(8'h24, 8'hFF);
        rd(8'h24, 8'h86, "R3");
        wr(8'h23, 8'h00);
        wr(8'h22, 8'h02);
        run_frames(2);

        // R2 unmapped address ignored
        wr(8'h25, 8'hAA);
        rd(8'h25, 8'h00, "R2");
        rd(8'h24, 8'h86, "R2");
        rd(8'h22, 8'h02, "R2");

        // R7 low polarity with two-line pulse
        wr(8'h24, 8'h01);
        run_frames(2);

        repeat (3) @(posedge clk);
        @(negedge clk); #2;
        finish_run();
    end

endmodule